// File: doc/BRIEF.md
# Partially Maskable Priority Interrupt Selector

This block sits beside a processor core and decides which of fourteen interrupt sources is serviced next. Each source owns a pending bit that is set by a request pulse on its line, or, for the six timer sources, by a timer match event. When the core raises its sample strobe, the block looks at the pending bits, the per-source mask value and a global interrupt-enable flag. It then registers the index of the winning source together with a one-cycle valid flag and a one-hot clear pulse that acknowledges the taken request.

Priority is fixed: index 0 is the highest. The order is software trap (0), non-maskable (1), watchdog (2), external 0 (3), timers 0 to 4 (4 to 8), external 1 (9), timer 5 (10), external 2 (11), serial receive (12) and serial transmit (13). The three top sources skip the per-source mask but still obey the global enable. Every lower source also needs its own mask bit.

Taking an interrupt clears the global enable, and only a core write sets it again. The take output has no back-pressure. The sample strobe is the consumer's request, and every take is reported exactly once as a single-cycle valid.

Top module: `irq_priority_selector`

## Requirements
- R1: After reset, `take_valid_o` is 0, `take_idx_o` is 0, `take_clr_o` is all zeros, `pend_o` is all zeros and `ien_o` is 0.
- R2: A 1 on bit i of `req_i` at a clock edge sets pending bit i, which appears on `pend_o[i]` after that edge. A 1 on `tmr_match_i[k]` sets pending bit 4+k for k = 0..4, and sets bit 10 for k = 5.
- R3: While `ien_o` is 0, no source is taken, including sources 0 to 2, and all pending bits are kept.
- R4: Sources 0, 1 and 2 are eligible whenever they are pending and `ien_o` is 1, whatever their `mask_i` bits are.
- R5: A source with index 3 to 13 is eligible only when its pending bit and `mask_i` bit of the same index are both 1.
- R6: Among the eligible sources, the one with the lowest index is taken. Every other pending bit stays set.
- R7: A take happens at an edge where `sample_i` is 1 and some source is eligible. No take happens at an edge where `sample_i` is 0.
- R8: After the edge of a take, `take_valid_o` is 1 for one cycle. `take_idx_o` holds the winner as an unsigned binary number, and `take_clr_o` has only the winner's bit set. In every other cycle all three are zero.
- R9: The taken source's pending bit is cleared at the same edge that raises `take_valid_o`. If the same source requests again in that cycle, its pending bit stays 1.
- R10: A take clears `ien_o`. A 1 on `ien_wr_i` loads `ien_wdata_i` into `ien_o` at the edge, and this write wins over a take at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 14 | Request pulses, one per source index |
| tmr_match_i | input | 6 | Timer match events for timers 0 to 5 |
| mask_i | input | 14 | Per-source mask; bits 0 to 2 are not used |
| sample_i | input | 1 | Evaluation strobe from the core |
| ien_wr_i | input | 1 | Write strobe for the global enable |
| ien_wdata_i | input | 1 | Value written to the global enable |
| take_valid_o | output | 1 | One-cycle flag: an interrupt was taken |
| take_idx_o | output | 4 | Index of the taken source |
| take_clr_o | output | 14 | One-hot acknowledge of the taken source |
| pend_o | output | 14 | Current pending bits |
| ien_o | output | 1 | Current global enable |

## Verification
The bench aims at the mask boundary between index 2 and index 3. A design that masked the watchdog would lose it under an all-zero mask, and one that let external 0 bypass the mask would take it while it is masked. It pends the non-maskable source with the global enable off, which catches a design that treats index 1 as truly non-maskable. It also raises a new request on the source being taken in the same cycle, where a design that puts the clear after the set drops that request. Finally it checks the timer-to-index mapping and the case where a core write and a take meet at one edge, where a design that let the take win would leave interrupts disabled.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int SRC_COUNT   = 14;
  localparam int UNMASKED    = 3;
  localparam int TMR_COUNT   = 6;
  localparam int SRC_IDX_W   = $clog2(SRC_COUNT);

  // Source index served by timer k: timers 0..4 are contiguous from 4,
  // timer 5 sits after external request 1.
  function automatic int tmr_src(input int k);
    return (k < 5) ? (4 + k) : 10;
  endfunction
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int NSRC = irq_sel_pkg::SRC_COUNT,
  parameter int NTMR = irq_sel_pkg::TMR_COUNT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NTMR-1:0] tmr_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] pend_q;

  always_comb begin
    set_vec = req_i;
    for (int k = 0; k < NTMR; k++) begin
      set_vec[irq_sel_pkg::tmr_src(k)] = set_vec[irq_sel_pkg::tmr_src(k)] | tmr_i[k];
    end
  end

  // Clear first, then set: a fresh request in the take cycle survives.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_vec;
  end

  assign pend_o = pend_q;

  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(set_vec)) == $past(set_vec)));

  a_r9_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(clr_i & ~set_vec)) == '0));
endmodule

// File: rtl/irq_eligibility.sv
module irq_eligibility #(
  parameter int NSRC  = irq_sel_pkg::SRC_COUNT,
  parameter int NFREE = irq_sel_pkg::UNMASKED
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            gate_i,
  output logic [NSRC-1:0] elig_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < NFREE) begin : g_free
      assign elig_o[i] = gate_i & pend_i[i];
    end else begin : g_masked
      assign elig_o[i] = gate_i & pend_i[i] & mask_i[i];
    end
  end
endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick #(
  parameter int NSRC = irq_sel_pkg::SRC_COUNT,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] elig_i,
  output logic            any_o,
  output logic [IW-1:0]   win_o
);
  always_comb begin
    win_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_i[i]) win_o = IW'(i);
    end
    any_o = |elig_i;
  end

  always_comb begin
    if (any_o) begin
      a_r6_lowest_wins: assert ((elig_i & ((NSRC'(1) << win_o) - NSRC'(1))) == '0 && elig_i[win_o]);
    end
  end
endmodule

// File: rtl/irq_priority_selector.sv
module irq_priority_selector #(
  parameter int NSRC  = irq_sel_pkg::SRC_COUNT,
  parameter int NTMR  = irq_sel_pkg::TMR_COUNT,
  parameter int NFREE = irq_sel_pkg::UNMASKED,
  localparam int IW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NTMR-1:0] tmr_match_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            sample_i,
  input  logic            ien_wr_i,
  input  logic            ien_wdata_i,
  output logic            take_valid_o,
  output logic [IW-1:0]   take_idx_o,
  output logic [NSRC-1:0] take_clr_o,
  output logic [NSRC-1:0] pend_o,
  output logic            ien_o
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] clr_now;
  logic [IW-1:0]   win;
  logic            any_elig;
  logic            fire;
  logic            ien_q;
  logic            valid_q;
  logic [IW-1:0]   idx_q;
  logic [NSRC-1:0] clr_q;

  irq_pending_bank #(.NSRC(NSRC), .NTMR(NTMR)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .tmr_i  (tmr_match_i),
    .clr_i  (clr_now),
    .pend_o (pend)
  );

  irq_eligibility #(.NSRC(NSRC), .NFREE(NFREE)) u_elig (
    .pend_i (pend),
    .mask_i (mask_i),
    .gate_i (ien_q & sample_i),
    .elig_o (elig)
  );

  irq_priority_pick #(.NSRC(NSRC)) u_pick (
    .elig_i (elig),
    .any_o  (any_elig),
    .win_o  (win)
  );

  assign fire    = any_elig;
  assign clr_now = fire ? (NSRC'(1) << win) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q   <= 1'b0;
      valid_q <= 1'b0;
      idx_q   <= '0;
      clr_q   <= '0;
    end else begin
      if (ien_wr_i)  ien_q <= ien_wdata_i;
      else if (fire) ien_q <= 1'b0;
      valid_q <= fire;
      idx_q   <= fire ? win : '0;
      clr_q   <= clr_now;
    end
  end

  assign take_valid_o = valid_q;
  assign take_idx_o   = idx_q;
  assign take_clr_o   = clr_q;
  assign pend_o       = pend;
  assign ien_o        = ien_q;

  a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o |-> ($past(ien_o) && $past(sample_i)));

  a_r8_clr_matches: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o |-> (take_clr_o == (NSRC'(1) << take_idx_o)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !take_valid_o |-> (take_clr_o == '0 && take_idx_o == '0));

  a_r5_mask_honoured: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid_o && int'(take_idx_o) >= NFREE) |-> (($past(mask_i) >> take_idx_o) & NSRC'(1)) != '0);

  a_r10_enable_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid_o && !$past(ien_wr_i)) |-> !ien_o);

  a_r10_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ien_wr_i) |-> (ien_o == $past(ien_wdata_i)));
endmodule

// File: tb/irq_priority_selector_tb.sv
module irq_priority_selector_tb;
  localparam int CLK_P = 10;
  localparam int N     = 14;

  typedef struct packed {
    logic [13:0] req;
    logic [13:0] mask;
    logic        en;
    logic        exp_v;
    logic [3:0]  exp_idx;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{req: 14'h3FFF, mask: 14'h0000, en: 1'b1, exp_v: 1'b1, exp_idx: 4'd0},
    '{req: 14'h0004, mask: 14'h0000, en: 1'b1, exp_v: 1'b1, exp_idx: 4'd2},
    '{req: 14'h0008, mask: 14'h0000, en: 1'b1, exp_v: 1'b0, exp_idx: 4'd0},
    '{req: 14'h0008, mask: 14'h0008, en: 1'b1, exp_v: 1'b1, exp_idx: 4'd3},
    '{req: 14'h3000, mask: 14'h2000, en: 1'b1, exp_v: 1'b1, exp_idx: 4'd13},
    '{req: 14'h0001, mask: 14'h3FFF, en: 1'b0, exp_v: 1'b0, exp_idx: 4'd0},
    '{req: 14'h0610, mask: 14'h0600, en: 1'b1, exp_v: 1'b1, exp_idx: 4'd9},
    '{req: 14'h0006, mask: 14'h0000, en: 1'b0, exp_v: 1'b0, exp_idx: 4'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic [5:0]    tmr_match_i = '0;
  logic [N-1:0]  mask_i = '0;
  logic          sample_i = 1'b0;
  logic          ien_wr_i = 1'b0;
  logic          ien_wdata_i = 1'b0;
  logic          take_valid_o;
  logic [3:0]    take_idx_o;
  logic [N-1:0]  take_clr_o;
  logic [N-1:0]  pend_o;
  logic          ien_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_priority_selector u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .tmr_match_i  (tmr_match_i),
    .mask_i       (mask_i),
    .sample_i     (sample_i),
    .ien_wr_i     (ien_wr_i),
    .ien_wdata_i  (ien_wdata_i),
    .take_valid_o (take_valid_o),
    .take_idx_o   (take_idx_o),
    .take_clr_o   (take_clr_o),
    .pend_o       (pend_o),
    .ien_o        (ien_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change 1 time unit after a rising edge; outputs are read there too.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_i = '0; tmr_match_i = '0; mask_i = '0;
    sample_i = 1'b0; ien_wr_i = 1'b0; ien_wdata_i = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic load(input logic [N-1:0] r, input logic en);
    req_i = r; ien_wr_i = 1'b1; ien_wdata_i = en;
    tick();
    req_i = '0; ien_wr_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 valid", take_valid_o, 0);
    chk("R1 idx", take_idx_o, 0);
    chk("R1 clr", take_clr_o, 0);
    chk("R1 pend", pend_o, 0);
    chk("R1 ien", ien_o, 0);

    // Table walk: R3 R4 R5 R6 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      logic [N-1:0] exp_p;
      do_reset();
      load(VEC[v].req, VEC[v].en);
      chk($sformatf("R2 pend v%0d", v), pend_o, VEC[v].req);
      mask_i = VEC[v].mask; sample_i = 1'b1;
      tick();
      sample_i = 1'b0;
      exp_p = VEC[v].exp_v ? (VEC[v].req & ~(N'(1) << VEC[v].exp_idx)) : VEC[v].req;
      chk($sformatf("R6 valid v%0d", v), take_valid_o, VEC[v].exp_v);
      chk($sformatf("R6 idx v%0d", v), take_idx_o, VEC[v].exp_v ? VEC[v].exp_idx : 4'd0);
      chk($sformatf("R8 clr v%0d", v), take_clr_o, VEC[v].exp_v ? (N'(1) << VEC[v].exp_idx) : N'(0));
      chk($sformatf("R9 pend v%0d", v), pend_o, exp_p);
      chk($sformatf("R10 ien v%0d", v), ien_o, VEC[v].exp_v ? 1'b0 : VEC[v].en);
      tick();
      chk($sformatf("R8 one cycle v%0d", v), take_valid_o, 0);
    end

    // R2: timer mapping
    do_reset();
    tmr_match_i = 6'b100001;
    tick();
    tmr_match_i = '0;
    chk("R2 timer map", pend_o, 14'h0410);
    tmr_match_i = 6'b011110;
    tick();
    tmr_match_i = '0;
    chk("R2 timer map 1-4", pend_o, 14'h05F0);

    // R7: no take without sample strobe
    do_reset();
    load(14'h0002, 1'b1);
    tick();
    chk("R7 no strobe valid", take_valid_o, 0);
    chk("R7 no strobe pend", pend_o, 14'h0002);
    chk("R7 no strobe ien", ien_o, 1);

    // R9: re-request in the take cycle keeps the bit
    sample_i = 1'b1; req_i = 14'h0002;
    tick();
    sample_i = 1'b0; req_i = '0;
    chk("R9 rereq valid", take_valid_o, 1);
    chk("R9 rereq idx", take_idx_o, 1);
    chk("R9 rereq pend", pend_o, 14'h0002);

    // R3: enable now clear, sample again -> nothing
    sample_i = 1'b1;
    tick();
    sample_i = 1'b0;
    chk("R3 disabled valid", take_valid_o, 0);
    chk("R3 disabled pend", pend_o, 14'h0002);

    // R10: write in the same cycle as a take wins
    load(14'h0000, 1'b1);
    sample_i = 1'b1; ien_wr_i = 1'b1; ien_wdata_i = 1'b1;
    tick();
    sample_i = 1'b0; ien_wr_i = 1'b0;
    chk("R10 write wins valid", take_valid_o, 1);
    chk("R10 write wins ien", ien_o, 1);
    chk("R10 write wins pend", pend_o, 0);

    // R6: successive takes walk priority order
    do_reset();
    load(14'h2208, 1'b1);
    mask_i = 14'h3FFF;
    sample_i = 1'b1;
    tick();
    chk("R6 seq first", take_idx_o, 3);
    ien_wr_i = 1'b1; ien_wdata_i = 1'b1;
    tick();
    ien_wr_i = 1'b0;
    chk("R6 seq gap", take_valid_o, 0);
    tick();
    chk("R6 seq second", take_idx_o, 9);
    ien_wr_i = 1'b1; ien_wdata_i = 1'b1;
    tick();
    ien_wr_i = 1'b0;
    tick();
    sample_i = 1'b0;
    chk("R6 seq third", take_idx_o, 13);
    chk("R6 seq drained", pend_o, 0);

    // R5: masked source stays pending even with enable and strobe
    do_reset();
    load(14'h1000, 1'b1);
    mask_i = 14'h0FFF; sample_i = 1'b1;
    tick();
    sample_i = 1'b0;
    chk("R5 masked valid", take_valid_o, 0);
    chk("R5 masked pend", pend_o, 14'h1000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule